// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by fetching mapping entries from memory. A caller hands it a 32-bit linear address, whether the access is a write, and whether it comes from user mode. The walker reads a directory entry, located from the directory base frame and the top ten address bits. It then reads a table entry, located from the frame in that directory entry and the middle ten address bits. It ends with either a fill record for the translation buffer or a page fault.

Along the way it marks each entry it passes through as accessed. It marks the leaf entry dirty when the access is a write. Each of these marks costs a write-back only when the stored word actually changes. Presence and user/write permission are enforced at both levels. A fault leaves behind the linear address that caused it and a three-bit error code for the exception logic.

All memory traffic uses one 32-bit word port. The port holds its request until acknowledged. Only one walk is in flight at a time.

Top module: `ptw_walker`

## Requirements
- R1: The directory word is read at {dir_frame, va[31:22], 2'b00} and the table word at {directory entry[31:12], va[21:12], 2'b00}.
- R2: A successful walk raises fill_valid for exactly one cycle with fill_vpn = va[31:12] and fill_frame = table entry[31:12].
- R3: Entry bit 5 (accessed) is set in every entry the walk uses successfully. The entry is written back with bit 5 set only when that bit was clear; an entry already marked is never written.
- R4: On a write walk that succeeds, bit 6 (dirty) of the table entry is set in memory. A read walk never sets bit 6, and the directory entry's bit 6 is never changed.
- R5: Bit 0 (present) clear in the directory entry gives a fault with no further memory access. Bit 0 clear in the table entry gives a fault with the table entry left unwritten. In both cases error code bit 0 is 0.
- R6: A user access (req_user = 1) to an entry whose bit 2 (user) is clear, at either level, gives a fault with error code bit 0 = 1. The offending entry and all later entries are left unwritten.
- R7: A user write to an entry whose bit 1 (writable) is clear, at either level, gives a protection fault. A supervisor write ignores bit 1 at both levels.
- R8: On a fault, fault_valid pulses for one cycle. fault_addr takes the full faulting linear address and keeps it until the next fault. fault_code is {user, write, protection} in bits [2:0].
- R9: While mem_req is high without mem_ack, the address, direction and write data stay unchanged into the next cycle.
- R10: req_ready is high only while no walk is running. A request presented while a walk is running is ignored.
- R11: fill_user is the AND of bit 2 of both entries, and fill_writable is the AND of bit 1 of both entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| dir_frame | input | 20 | Frame number of the directory |
| mem_req | output | 1 | Memory word access request |
| mem_we | output | 1 | Access is a write-back |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |
| fill_valid | output | 1 | Fill record valid (one cycle) |
| fill_vpn | output | 20 | Virtual page number of the fill |
| fill_frame | output | 20 | Physical frame of the fill |
| fill_user | output | 1 | Effective user permission |
| fill_writable | output | 1 | Effective write permission |
| fault_valid | output | 1 | Page fault (one cycle) |
| fault_addr | output | 32 | Last faulting linear address |
| fault_code | output | 3 | {user, write, protection} |

## Verification
The assertions assume that mem_ack comes only while mem_req is high and lasts a single cycle. They also assume that dir_frame stays steady during a walk. The bench's memory responder raises the acknowledge for one cycle, and only after a random wait of zero to two cycles on a pending request. The bench changes dir_frame only between walks. It places tables in the upper half of the address space and directories in the lower half, so the two lookups of a walk never hit the same word.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ADDR_W  = 32;
  localparam int IDX_W   = 10;
  localparam int OFF_W   = 12;
  localparam int FRAME_W = ADDR_W - OFF_W;
  localparam int SLOT_W  = OFF_W - IDX_W;
  localparam int CODE_W  = 3;

  localparam int B_PRES = 0;
  localparam int B_WRT  = 1;
  localparam int B_USR  = 2;
  localparam int B_ACC  = 5;
  localparam int B_DRT  = 6;

  typedef logic [ADDR_W-1:0] word_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_DIR, ST_WR_DIR, ST_RD_TBL, ST_WR_TBL, ST_DONE, ST_FAULT
  } walk_st_e;

  typedef struct packed {
    logic user;
    logic write;
    logic prot;
  } flt_code_t;

  // byte address of a table slot: frame, index, word alignment
  function automatic word_t slot_addr(input logic [FRAME_W-1:0] frame,
                                      input logic [IDX_W-1:0] idx);
    return {frame, idx, {SLOT_W{1'b0}}};
  endfunction

  // permission refusal for one entry
  function automatic logic denies(input word_t e, input logic usr, input logic wr);
    return usr && (!e[B_USR] || (wr && !e[B_WRT]));
  endfunction

  // entry after the walk's status marks
  function automatic word_t mark(input word_t e, input logic set_dirty);
    word_t r;
    r = e;
    r[B_ACC] = 1'b1;
    if (set_dirty) r[B_DRT] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
  import ptw_pkg::*;
#(
  parameter bit LEAF = 1'b0
) (
  input  word_t entry,
  input  logic  usr,
  input  logic  wr,
  output logic  absent,
  output logic  denied,
  output word_t marked,
  output logic  changed
);
  assign absent = !entry[B_PRES];
  assign denied = denies(entry, usr, wr);

  generate
    if (LEAF) begin : g_leaf
      assign marked = mark(entry, wr);
    end else begin : g_dir
      assign marked = mark(entry, 1'b0);
    end
  endgenerate

  assign changed = (marked != entry);
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  walk_st_e           st,
  input  logic [FRAME_W-1:0] dir_frame,
  input  logic [FRAME_W-1:0] tbl_frame,
  input  logic [IDX_W-1:0]   dir_idx,
  input  logic [IDX_W-1:0]   tbl_idx,
  output word_t              addr
);
  logic tbl_phase;
  assign tbl_phase = (st == ST_RD_TBL) || (st == ST_WR_TBL);
  assign addr = tbl_phase ? slot_addr(tbl_frame, tbl_idx)
                          : slot_addr(dir_frame, dir_idx);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_vaddr,
  input  logic               req_write,
  input  logic               req_user,
  input  logic [FRAME_W-1:0] dir_frame,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [ADDR_W-1:0]  mem_wdata,
  input  logic               mem_ack,
  input  logic [ADDR_W-1:0]  mem_rdata,
  output logic               fill_valid,
  output logic [FRAME_W-1:0] fill_vpn,
  output logic [FRAME_W-1:0] fill_frame,
  output logic               fill_user,
  output logic               fill_writable,
  output logic               fault_valid,
  output logic [ADDR_W-1:0]  fault_addr,
  output logic [CODE_W-1:0]  fault_code
);
  walk_st_e  st, st_nx;
  word_t     va_q, pde_q, pte_q, flt_addr_q;
  logic      wr_q, us_q;
  flt_code_t flt_code_q;

  // named internal events
  logic ev_start, ev_dir_arrive, ev_tbl_arrive, ev_enter_fault, tbl_phase;
  assign ev_start       = req_valid && (st == ST_IDLE);
  assign ev_dir_arrive  = (st == ST_RD_DIR) && mem_ack;
  assign ev_tbl_arrive  = (st == ST_RD_TBL) && mem_ack;
  assign ev_enter_fault = (st_nx == ST_FAULT) && (st != ST_FAULT);
  assign tbl_phase      = (st == ST_RD_TBL) || (st == ST_WR_TBL);

  logic  dir_absent, dir_denied, dir_changed;
  logic  tbl_absent, tbl_denied, tbl_changed;
  word_t dir_marked, tbl_marked;

  ptw_entry_eval #(.LEAF(1'b0)) u_dir_eval (
    .entry(mem_rdata), .usr(us_q), .wr(wr_q),
    .absent(dir_absent), .denied(dir_denied),
    .marked(dir_marked), .changed(dir_changed)
  );

  ptw_entry_eval #(.LEAF(1'b1)) u_tbl_eval (
    .entry(mem_rdata), .usr(us_q), .wr(wr_q),
    .absent(tbl_absent), .denied(tbl_denied),
    .marked(tbl_marked), .changed(tbl_changed)
  );

  ptw_addr_gen u_addr (
    .st(st),
    .dir_frame(dir_frame),
    .tbl_frame(pde_q[ADDR_W-1 -: FRAME_W]),
    .dir_idx(va_q[ADDR_W-1 -: IDX_W]),
    .tbl_idx(va_q[OFF_W +: IDX_W]),
    .addr(mem_addr)
  );

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:   if (ev_start) st_nx = ST_RD_DIR;
      ST_RD_DIR: if (mem_ack)
                   st_nx = (dir_absent || dir_denied) ? ST_FAULT :
                           dir_changed ? ST_WR_DIR : ST_RD_TBL;
      ST_WR_DIR: if (mem_ack) st_nx = ST_RD_TBL;
      ST_RD_TBL: if (mem_ack)
                   st_nx = (tbl_absent || tbl_denied) ? ST_FAULT :
                           tbl_changed ? ST_WR_TBL : ST_DONE;
      ST_WR_TBL: if (mem_ack) st_nx = ST_DONE;
      default:   st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      va_q       <= '0;
      wr_q       <= 1'b0;
      us_q       <= 1'b0;
      pde_q      <= '0;
      pte_q      <= '0;
      flt_addr_q <= '0;
      flt_code_q <= '0;
    end else begin
      st <= st_nx;
      if (ev_start) begin
        va_q <= req_vaddr;
        wr_q <= req_write;
        us_q <= req_user;
      end
      if (ev_dir_arrive) pde_q <= dir_marked;
      if (ev_tbl_arrive) pte_q <= tbl_marked;
      if (ev_enter_fault) begin
        flt_addr_q       <= va_q;
        flt_code_q.user  <= us_q;
        flt_code_q.write <= wr_q;
        flt_code_q.prot  <= ev_dir_arrive ? !dir_absent : !tbl_absent;
      end
    end
  end

  assign req_ready     = (st == ST_IDLE);
  assign mem_req       = (st == ST_RD_DIR) || (st == ST_WR_DIR) ||
                         (st == ST_RD_TBL) || (st == ST_WR_TBL);
  assign mem_we        = (st == ST_WR_DIR) || (st == ST_WR_TBL);
  assign mem_wdata     = (st == ST_WR_DIR) ? pde_q : pte_q;
  assign fill_valid    = (st == ST_DONE);
  assign fill_vpn      = va_q[ADDR_W-1 -: FRAME_W];
  assign fill_frame    = pte_q[ADDR_W-1 -: FRAME_W];
  assign fill_user     = pde_q[B_USR] & pte_q[B_USR];
  assign fill_writable = pde_q[B_WRT] & pte_q[B_WRT];
  assign fault_valid   = (st == ST_FAULT);
  assign fault_addr    = flt_addr_q;
  assign fault_code    = flt_code_q;
endmodule

// File: rtl/ptw_walker_sva.sv
module ptw_walker_sva
  import ptw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] mem_wdata,
  input logic              fill_valid,
  input logic              fault_valid,
  input logic [CODE_W-1:0] fault_code,
  input logic              walk_write,
  input logic              tbl_phase
);
  a_r9_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                            && $stable(mem_wdata));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);

  a_r3_writeback_marks_accessed: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[B_ACC]);

  a_r4_write_walk_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && tbl_phase && walk_write |-> mem_wdata[B_DRT]);

  a_r2_fill_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> !fill_valid && req_ready);

  a_r8_fault_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> !fault_valid && req_ready);

  a_r8_code_write_bit: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> fault_code[1] == walk_write);
endmodule

bind ptw_walker ptw_walker_sva u_sva (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .fill_valid(fill_valid), .fault_valid(fault_valid),
  .fault_code(fault_code), .walk_write(wr_q), .tbl_phase(tbl_phase)
);

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [19:0] dir_frame = '0;
  logic        req_ready, mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        fill_valid, fill_user, fill_writable, fault_valid;
  logic [19:0] fill_vpn, fill_frame;
  logic [31:0] fault_addr;
  logic [2:0]  fault_code;

  ptw_walker u_dut (.*);

  always #2 clk = ~clk;

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit [31:0] mem [bit [31:0]];
  bit [31:0] cur_dir_a, cur_tbl_a, rd_addr0, last_fault_va = 0;
  int n_rd = 0, n_wr_dir = 0, n_wr_tbl = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // memory responder: random wait, one-cycle acknowledge
  initial begin
    int wait_c = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (wait_c == 0) begin
          mem_ack = 1'b1;
          if (mem_we) begin
            mem[mem_addr] = mem_wdata;
            if (mem_addr == cur_dir_a) n_wr_dir++;
            if (mem_addr == cur_tbl_a) n_wr_tbl++;
          end else begin
            if (n_rd == 0) rd_addr0 = mem_addr;
            n_rd++;
            mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
          end
          wait_c = $urandom % 3;
        end else wait_c--;
      end
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        finish_run();
      end
    end
  end

  // expected outcome from the requirements
  task automatic expect_walk(input bit [31:0] pde, input bit [31:0] pte, input bit wr, input bit us,
                             output bit e_fault, output bit [2:0] e_code,
                             output bit [31:0] e_pde, output bit [31:0] e_pte,
                             output int e_dwr, output int e_rd, output int e_twr);
    e_pde = pde; e_pte = pte; e_dwr = 0; e_twr = 0; e_rd = 1; e_fault = 0; e_code = 0;
    if (!pde[0]) begin
      e_fault = 1; e_code = {us, wr, 1'b0};
    end else if (us && (!pde[2] || (wr && !pde[1]))) begin
      e_fault = 1; e_code = {us, wr, 1'b1};
    end else begin
      e_dwr = pde[5] ? 0 : 1;
      e_pde[5] = 1'b1;
      e_rd = 2;
      if (!pte[0]) begin
        e_fault = 1; e_code = {us, wr, 1'b0};
      end else if (us && (!pte[2] || (wr && !pte[1]))) begin
        e_fault = 1; e_code = {us, wr, 1'b1};
      end else begin
        e_pte[5] = 1'b1;
        if (wr) e_pte[6] = 1'b1;
        e_twr = (e_pte != pte) ? 1 : 0;
      end
    end
  endtask

  task automatic run_case(input bit [19:0] dfr, input bit [31:0] va, input bit [31:0] pde,
                          input bit [31:0] pte, input bit wr, input bit us, input bit intrude);
    bit e_fault; bit [2:0] e_code; bit [31:0] e_pde, e_pte;
    int e_dwr, e_rd, e_twr, guard;
    bit got_fill, got_fault;
    mem.delete();
    cur_dir_a = {dfr, va[31:22], 2'b00};
    cur_tbl_a = {pde[31:12], va[21:12], 2'b00};
    mem[cur_dir_a] = pde;
    mem[cur_tbl_a] = pte;
    n_rd = 0; n_wr_dir = 0; n_wr_tbl = 0;
    expect_walk(pde, pte, wr, us, e_fault, e_code, e_pde, e_pte, e_dwr, e_rd, e_twr);
    @(negedge clk);
    dir_frame = dfr; req_vaddr = va; req_write = wr; req_user = us; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    got_fill = 0; got_fault = 0; guard = 0;
    while (!got_fill && !got_fault && guard < 200) begin
      if (intrude && guard == 1) begin
        chk("R10 ready low while busy", {31'b0, req_ready}, 32'h0);
        req_valid = 1'b1; req_vaddr = ~va; req_write = ~wr;
      end
      got_fill = fill_valid; got_fault = fault_valid;
      if (!got_fill && !got_fault) begin
        @(negedge clk);
        guard++;
      end
    end
    req_valid = 1'b0;
    chk("R5/R6/R7 fault outcome", {31'b0, got_fault}, {31'b0, e_fault});
    chk("R2 outcome present", {31'b0, got_fill | got_fault}, 32'h1);
    chk("R1 directory address", rd_addr0, cur_dir_a);
    chk("R1/R5 read count", n_rd, e_rd);
    chk("R3 directory writes", n_wr_dir, e_dwr);
    chk("R3 directory word", mem[cur_dir_a], e_pde);
    chk("R3/R4 table writes", n_wr_tbl, e_twr);
    chk("R4 table word", mem[cur_tbl_a], e_pte);
    if (got_fault) begin
      last_fault_va = va;
      chk("R8 fault code", {29'b0, fault_code}, {29'b0, e_code});
      chk("R8 fault address", fault_addr, va);
    end else if (got_fill) begin
      chk("R2 fill vpn", {12'b0, fill_vpn}, {12'b0, va[31:12]});
      chk("R2 fill frame", {12'b0, fill_frame}, {12'b0, pte[31:12]});
      chk("R11 fill user", {31'b0, fill_user}, {31'b0, pde[2] & pte[2]});
      chk("R11 fill writable", {31'b0, fill_writable}, {31'b0, pde[1] & pte[1]});
      chk("R8 fault address held", fault_addr, last_fault_va);
    end
    @(negedge clk);
    chk("R2 one-cycle result", {31'b0, fill_valid | fault_valid}, 32'h0);
  endtask

  function automatic bit [31:0] rnd_entry(input bit upper);
    bit [31:0] e;
    e = $urandom;
    e[31] = upper;
    e[0] = ($urandom % 8) != 0;
    return e;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset ready", {31'b0, req_ready}, 32'h1);
    chk("R9 reset no request", {31'b0, mem_req}, 32'h0);
    chk("R2 reset no fill", {31'b0, fill_valid}, 32'h0);
    chk("R8 reset fault addr", fault_addr, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners: pde bits {U,W,P}=bit2..0, A=bit5, D=bit6
    run_case(20'h00010, 32'h1234_5678, 32'h8000_2006, 32'h0, 1'b0, 1'b0, 1'b0); // R5 dir absent
    run_case(20'h00011, 32'h0040_1ABC, 32'h8000_3007, 32'h0009_9006, 1'b1, 1'b0, 1'b0); // R5 pte absent
    run_case(20'h00012, 32'hFFC0_0004, 32'h8000_4003, 32'h0001_1007, 1'b0, 1'b1, 1'b0); // R6 dir supervisor
    run_case(20'h00013, 32'h0080_2000, 32'h8000_5007, 32'h0002_2005, 1'b1, 1'b1, 1'b0); // R7 pte read-only
    run_case(20'h00014, 32'h00C0_3000, 32'h8000_6005, 32'h0003_3007, 1'b1, 1'b1, 1'b0); // R7 dir read-only
    run_case(20'h00015, 32'h0100_4000, 32'h8000_7001, 32'h0004_4001, 1'b1, 1'b0, 1'b0); // R7 supervisor write
    run_case(20'h00016, 32'h0140_5000, 32'h8000_8027, 32'h0005_5067, 1'b1, 1'b1, 1'b0); // R3 no writes
    run_case(20'h00017, 32'h0180_6000, 32'h8000_9027, 32'h0006_6027, 1'b0, 1'b1, 1'b0); // R4 read keeps D clear
    run_case(20'h00018, 32'h01C0_7000, 32'h8000_A007, 32'h0007_7007, 1'b0, 1'b0, 1'b1); // R10 intrusion

    for (int i = 0; i < 250; i++) begin
      bit [19:0] dfr;
      dfr = $urandom;
      dfr[19] = 1'b0;
      run_case(dfr, $urandom, rnd_entry(1'b1), rnd_entry(1'b0), $urandom % 2, $urandom % 2,
               (i % 25) == 0);
    end
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0386));
  end
endmodule